// File: doc/BRIEF.md
# Write-Once Node Identifier and Configuration ROM Map Registers

This unit holds the 64-bit unique identifier of a node as two 32-bit words, upper at offset 24h and lower at offset 28h, plus a base-address register for the configuration ROM at offset 34h. Each identifier word starts at zero, which is not a legal identifier. It can then be filled exactly once, from one of two sources, and after that it is frozen until the next global reset. When the EEPROM-present flag is high, only the EEPROM load port can fill the words. When the flag is low, one host register write fills each word.

The unit also turns quadlet read requests into host memory addresses. A request whose 48-bit offset lies in the configuration ROM window, FFFF_F000_0400h to FFFF_F000_07FFh inclusive, produces the mapping base plus the low ten offset bits. Every other request raises a miss flag instead. Host register reads and translation results are both registered and appear one cycle after their strobe.

Top module: `node_id_regs`

## Requirements
- R1: While `grst_n` is low at a clock edge, both identifier words, both lock bits and the mapping register clear. After that edge `reg_rdata`, `xl_valid`, `xl_miss` and `xl_addr` are all zero.
- R2: An EEPROM load strobe (`ee_load_hi` for offset 24h, `ee_load_lo` for offset 28h) stores `ee_data` into an unlocked word and locks it, but only while `ee_present` is high. With `ee_present` low the strobe has no effect.
- R3: After a word is locked, later EEPROM loads and host writes to it leave it unchanged. Only a global reset clears the word and its lock.
- R4: With `ee_present` low, a host write to 24h or 28h stores `reg_wdata` into the unlocked word and locks it. With `ee_present` high, host writes to those offsets are ignored.
- R5: A host write to 34h stores bits 31:10 of `reg_wdata`. Reads of 34h return bits 9:0 as zero.
- R6: A request with `xl_quadlet` high and `xl_offset` in FFFF_F000_0400h to FFFF_F000_07FFh gives `xl_valid`=1, `xl_miss`=0 and `xl_addr` = mapping register + `xl_offset[9:0]` on the next cycle.
- R7: A request outside the window, or one with `xl_quadlet` low, gives `xl_miss`=1 and `xl_valid`=0 on the next cycle. A cycle without a request gives both flags low on the next cycle.
- R8: `reg_rdata` carries the value of the addressed register on the cycle after `reg_rd`. It is zero for unmapped offsets and on cycles after no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| grst_n | input | 1 | Global reset, synchronous, active low |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 8 | Host register offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Registered read data |
| ee_present | input | 1 | EEPROM detected |
| ee_load_hi | input | 1 | EEPROM load strobe, upper identifier word |
| ee_load_lo | input | 1 | EEPROM load strobe, lower identifier word |
| ee_data | input | 32 | EEPROM load data |
| xl_req | input | 1 | Translation request strobe |
| xl_quadlet | input | 1 | Request is a quadlet read |
| xl_offset | input | 48 | Requested 48-bit offset |
| xl_valid | output | 1 | Translation produced an address |
| xl_miss | output | 1 | Request not translatable |
| xl_addr | output | 32 | Translated host address |

## Verification
The properties assume that `grst_n` is the only reset and that every strobe is sampled at one clock edge. They also assume that the EEPROM-present flag changes only between load sequences and never in the cycle of a load it would gate. The bench drives all inputs just after the falling edge and changes `ee_present` only while no strobe is active, so each load has one unambiguous source. Translation requests are single-cycle pulses, so the one-cycle response properties never see requests that overlap.

// File: rtl/node_id_pkg.sv
// Package: offsets and shared widths for the node identifier register unit.
// Assumes byte offsets of 8 bits and 32-bit register words.
package node_id_pkg;
    localparam int unsigned REG_AW   = 8;
    localparam int unsigned REG_DW   = 32;
    localparam int unsigned OFS_W    = 48;
    localparam int unsigned SPAN_W   = 10;
    localparam int unsigned ID_WORDS = 2;

    localparam logic [REG_AW-1:0] ADDR_ID_HI = 8'h24;
    localparam logic [REG_AW-1:0] ADDR_ID_LO = 8'h28;
    localparam logic [REG_AW-1:0] ADDR_MAP   = 8'h34;

    localparam logic [OFS_W-1:0] ROM_WIN_BASE = 48'hFFFF_F000_0400;
endpackage

// File: rtl/node_id_word.sv
// Module: one write-once identifier word.
// The word takes a single load, from the EEPROM port when ee_present is high
// or from a host write when it is low, and then locks. Only grst_n clears it.
// Assumes that load strobes are single-cycle and synchronous to clk.
module node_id_word #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          grst_n,
    input  logic          ee_present,
    input  logic          ee_load,
    input  logic [DW-1:0] ee_data,
    input  logic          host_wr,
    input  logic [DW-1:0] host_data,
    output logic [DW-1:0] value,
    output logic          locked
);
    logic take_ee;
    logic take_host;

    // Select the load source that the present flag allows.
    always_comb begin
        take_ee   = !locked && ee_present && ee_load;
        take_host = !locked && !ee_present && host_wr;
    end

    // Store the first allowed load and set the lock bit.
    always_ff @(posedge clk) begin
        if (!grst_n) begin
            value  <= '0;
            locked <= 1'b0;
        end else if (take_ee) begin
            value  <= ee_data;
            locked <= 1'b1;
        end else if (take_host) begin
            value  <= host_data;
            locked <= 1'b1;
        end
    end
endmodule

// File: rtl/rom_map_xlate.sv
// Module: configuration ROM mapping register and offset translator.
// Keeps only the upper DW-SPAN_W bits of the base. Offsets inside the
// 2**SPAN_W byte window that starts at WIN_BASE become base + low offset bits.
// Assumes WIN_BASE is aligned to 2**SPAN_W.
module rom_map_xlate #(
    parameter int unsigned DW       = 32,
    parameter int unsigned OW       = 48,
    parameter int unsigned SPAN_W   = 10,
    parameter logic [OW-1:0] WIN_BASE = 48'hFFFF_F000_0400
) (
    input  logic          clk,
    input  logic          grst_n,
    input  logic          map_wr,
    input  logic [DW-1:0] map_wdata,
    output logic [DW-1:0] map_value,
    input  logic          req,
    input  logic          quadlet,
    input  logic [OW-1:0] offset,
    output logic          valid,
    output logic          miss,
    output logic [DW-1:0] addr
);
    localparam int unsigned BASE_W = DW - SPAN_W;

    logic [BASE_W-1:0] base_q;
    logic              in_win;
    logic [DW-1:0]     sum;

    // Keep the writable upper part of the mapping base.
    always_ff @(posedge clk) begin
        if (!grst_n)
            base_q <= '0;
        else if (map_wr)
            base_q <= map_wdata[DW-1:SPAN_W];
    end

    // Present the base with the reserved low bits tied to zero.
    always_comb map_value = {base_q, {SPAN_W{1'b0}}};

    // Decode the window and form the host address.
    always_comb begin
        in_win = (offset[OW-1:SPAN_W] == WIN_BASE[OW-1:SPAN_W]);
        sum    = map_value + {{BASE_W{1'b0}}, offset[SPAN_W-1:0]};
    end

    // Register the translation outcome for one-cycle latency.
    always_ff @(posedge clk) begin
        if (!grst_n) begin
            valid <= 1'b0;
            miss  <= 1'b0;
            addr  <= '0;
        end else begin
            valid <= req && quadlet && in_win;
            miss  <= req && !(quadlet && in_win);
            addr  <= (req && quadlet && in_win) ? sum : '0;
        end
    end
endmodule

// File: rtl/node_id_regs.sv
// Module: top of the node identifier register unit.
// Holds two write-once identifier words, the ROM mapping register and the
// read-offset translator behind a simple strobe-based register bus.
// Assumes that reg_wr and reg_rd are single-cycle strobes with a stable address.
module node_id_regs
    import node_id_pkg::*;
(
    input  logic              clk,
    input  logic              grst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              ee_present,
    input  logic              ee_load_hi,
    input  logic              ee_load_lo,
    input  logic [REG_DW-1:0] ee_data,
    input  logic              xl_req,
    input  logic              xl_quadlet,
    input  logic [OFS_W-1:0]  xl_offset,
    output logic              xl_valid,
    output logic              xl_miss,
    output logic [REG_DW-1:0] xl_addr
);
    localparam logic [REG_AW-1:0] ID_ADDR [ID_WORDS] = '{ADDR_ID_HI, ADDR_ID_LO};

    logic [REG_DW-1:0] id_val  [ID_WORDS];
    logic              id_lock [ID_WORDS];
    logic [ID_WORDS-1:0] ee_strobe;
    logic [REG_DW-1:0] map_value;
    logic [REG_DW-1:0] id_hi_q;
    logic [REG_DW-1:0] id_lo_q;
    logic              lock_hi;
    logic              lock_lo;
    logic              map_wr;

    // Group the EEPROM strobes by word index (0 = upper, 1 = lower).
    always_comb ee_strobe = {ee_load_lo, ee_load_hi};

    // One write-once word per identifier half.
    for (genvar gi = 0; gi < ID_WORDS; gi++) begin : g_id
        node_id_word #(.DW(REG_DW)) u_word (
            .clk       (clk),
            .grst_n    (grst_n),
            .ee_present(ee_present),
            .ee_load   (ee_strobe[gi]),
            .ee_data   (ee_data),
            .host_wr   (reg_wr && (reg_addr == ID_ADDR[gi])),
            .host_data (reg_wdata),
            .value     (id_val[gi]),
            .locked    (id_lock[gi])
        );
    end

    // Name the word outputs for readback and for the checker.
    always_comb begin
        id_hi_q = id_val[0];
        id_lo_q = id_val[1];
        lock_hi = id_lock[0];
        lock_lo = id_lock[1];
        map_wr  = reg_wr && (reg_addr == ADDR_MAP);
    end

    rom_map_xlate #(
        .DW      (REG_DW),
        .OW      (OFS_W),
        .SPAN_W  (SPAN_W),
        .WIN_BASE(ROM_WIN_BASE)
    ) u_xlate (
        .clk      (clk),
        .grst_n   (grst_n),
        .map_wr   (map_wr),
        .map_wdata(reg_wdata),
        .map_value(map_value),
        .req      (xl_req),
        .quadlet  (xl_quadlet),
        .offset   (xl_offset),
        .valid    (xl_valid),
        .miss     (xl_miss),
        .addr     (xl_addr)
    );

    // Registered read port; zero when idle or unmapped.
    always_ff @(posedge clk) begin
        if (!grst_n || !reg_rd)
            reg_rdata <= '0;
        else begin
            unique case (reg_addr)
                ADDR_ID_HI: reg_rdata <= id_hi_q;
                ADDR_ID_LO: reg_rdata <= id_lo_q;
                ADDR_MAP:   reg_rdata <= map_value;
                default:    reg_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/node_id_regs_chk.sv
// Module: property checker for node_id_regs, attached by bind.
// Assumes grst_n is the only reset and that strobes are sampled at one edge.
module node_id_regs_chk
    import node_id_pkg::*;
(
    input logic              clk,
    input logic              grst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_rdata,
    input logic              ee_present,
    input logic              ee_load_hi,
    input logic              xl_req,
    input logic [OFS_W-1:0]  xl_offset,
    input logic              xl_valid,
    input logic              xl_miss,
    input logic [REG_DW-1:0] xl_addr,
    input logic [REG_DW-1:0] id_hi_q,
    input logic [REG_DW-1:0] id_lo_q,
    input logic              lock_hi,
    input logic              lock_lo
);
    AST_HI_FROZEN: assert property (@(posedge clk) disable iff (!grst_n)
        lock_hi |=> (lock_hi && $stable(id_hi_q)));                          // R3
    AST_LO_FROZEN: assert property (@(posedge clk) disable iff (!grst_n)
        lock_lo |=> (lock_lo && $stable(id_lo_q)));                          // R3
    AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!grst_n)
        (ee_present && !lock_hi && !ee_load_hi && reg_wr && reg_addr == ADDR_ID_HI)
        |=> !lock_hi);                                                       // R4
    AST_XL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!grst_n)
        !(xl_valid && xl_miss));                                             // R7
    AST_XL_ANSWERED: assert property (@(posedge clk) disable iff (!grst_n)
        xl_req |=> (xl_valid || xl_miss));                                   // R6
    AST_XL_QUIET: assert property (@(posedge clk) disable iff (!grst_n)
        !xl_req |=> (!xl_valid && !xl_miss));                                // R7
    AST_XL_LOW_BITS: assert property (@(posedge clk) disable iff (!grst_n)
        xl_valid |-> (xl_addr[SPAN_W-1:0] == $past(xl_offset[SPAN_W-1:0]))); // R6
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!grst_n)
        !reg_rd |=> (reg_rdata == '0));                                      // R8
endmodule

bind node_id_regs node_id_regs_chk u_chk (.*);

// File: tb/node_id_regs_test.sv
// Bench for node_id_regs: a translation vector table walked by one loop, then
// directed checks of reset, load sources, locking and register readback.
module node_id_regs_test;
    logic        clk = 1'b0;
    logic        grst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ee_present = 1'b0;
    logic        ee_load_hi = 1'b0;
    logic        ee_load_lo = 1'b0;
    logic [31:0] ee_data = '0;
    logic        xl_req = 1'b0;
    logic        xl_quadlet = 1'b0;
    logic [47:0] xl_offset = '0;
    logic        xl_valid;
    logic        xl_miss;
    logic [31:0] xl_addr;

    int total = 0;
    int bad = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    node_id_regs uut (.*);

    // Fields: quadlet[82], offset[81:34], valid[33], miss[32], addr[31:0].
    localparam int NV = 8;
    localparam logic [82:0] VEC [NV] = '{
        {1'b1, 48'hFFFF_F000_0400, 1'b1, 1'b0, 32'hABCD_E400},
        {1'b1, 48'hFFFF_F000_07FC, 1'b1, 1'b0, 32'hABCD_E7FC},
        {1'b1, 48'hFFFF_F000_0404, 1'b1, 1'b0, 32'hABCD_E404},
        {1'b1, 48'hFFFF_F000_03FC, 1'b0, 1'b1, 32'h0},
        {1'b1, 48'hFFFF_F000_0800, 1'b0, 1'b1, 32'h0},
        {1'b0, 48'hFFFF_F000_0500, 1'b0, 1'b1, 32'h0},
        {1'b1, 48'h0000_0000_0400, 1'b0, 1'b1, 32'h0},
        {1'b1, 48'hFFFF_F000_07FF, 1'b1, 1'b0, 32'hABCD_E7FF}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic ee_load(input logic hi, input logic [31:0] d);
        ee_load_hi = hi; ee_load_lo = !hi; ee_data = d;
        @(negedge clk);
        ee_load_hi = 1'b0; ee_load_lo = 1'b0;
    endtask

    task automatic do_reset();
        grst_n = 1'b0;
        repeat (2) @(negedge clk);
        grst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        do_reset();

        // R1: reset state
        chk("R1 valid", {31'b0, xl_valid}, 32'h0);
        chk("R1 miss", {31'b0, xl_miss}, 32'h0);
        host_read(8'h24, rv); chk("R1 id hi", rv, 32'h0);
        host_read(8'h28, rv); chk("R1 id lo", rv, 32'h0);
        host_read(8'h34, rv); chk("R1 map", rv, 32'h0);

        // R2: EEPROM load ignored while not present
        ee_load(1'b1, 32'hDEAD_0001);
        host_read(8'h24, rv); chk("R2 absent ee ignored", rv, 32'h0);

        // R4: host load with no EEPROM, then R3 lock
        host_write(8'h24, 32'h1111_2222);
        host_read(8'h24, rv); chk("R4 host load hi", rv, 32'h1111_2222);
        host_write(8'h24, 32'h3333_4444);
        host_read(8'h24, rv); chk("R3 host rewrite ignored", rv, 32'h1111_2222);
        host_write(8'h28, 32'h0BAD_CAFE);
        host_read(8'h28, rv); chk("R4 host load lo", rv, 32'h0BAD_CAFE);

        // R5: reserved map bits read zero
        host_write(8'h34, 32'hFFFF_FFFF);
        host_read(8'h34, rv); chk("R5 map reserved", rv, 32'hFFFF_FC00);
        host_write(8'h34, 32'hABCD_E5A5);
        host_read(8'h34, rv); chk("R5 map value", rv, 32'hABCD_E400);

        // R8: unmapped offset and idle cycle
        host_read(8'h40, rv); chk("R8 unmapped", rv, 32'h0);
        @(negedge clk); chk("R8 idle", reg_rdata, 32'h0);

        // R6 / R7: translation table
        for (int i = 0; i < NV; i++) begin
            xl_req = 1'b1; xl_quadlet = VEC[i][82]; xl_offset = VEC[i][81:34];
            @(negedge clk);
            xl_req = 1'b0;
            chk($sformatf("R6 valid v%0d", i), {31'b0, xl_valid}, {31'b0, VEC[i][33]});
            chk($sformatf("R7 miss v%0d", i), {31'b0, xl_miss}, {31'b0, VEC[i][32]});
            chk($sformatf("R6 addr v%0d", i), xl_addr, VEC[i][31:0]);
        end
        @(negedge clk);
        chk("R7 no request", {30'b0, xl_valid, xl_miss}, 32'h0);

        // R3: global reset clears locked words
        do_reset();
        host_read(8'h24, rv); chk("R3 reset clears hi", rv, 32'h0);

        // R4: host write blocked with EEPROM present; R2 EEPROM loads
        ee_present = 1'b1;
        @(negedge clk);
        host_write(8'h28, 32'h1234_5678);
        host_read(8'h28, rv); chk("R4 host blocked", rv, 32'h0);
        ee_load(1'b0, 32'h5555_AAAA);
        host_read(8'h28, rv); chk("R2 ee load lo", rv, 32'h5555_AAAA);
        ee_load(1'b0, 32'h6666_0000);
        host_read(8'h28, rv); chk("R3 ee reload ignored", rv, 32'h5555_AAAA);
        ee_load(1'b1, 32'h7777_8888);
        host_read(8'h24, rv); chk("R2 ee load hi", rv, 32'h7777_8888);
        ee_present = 1'b0;
        @(negedge clk);
        host_write(8'h24, 32'h9999_0000);
        host_read(8'h24, rv); chk("R3 host after ee ignored", rv, 32'h7777_8888);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule